// File: doc/BRIEF.md
# Private Interrupt Priority Arbiter

This block keeps the per-core state of 128 private interrupts and continuously reports the most urgent one that may be taken. The interrupts sit in two banks of 64. Each interrupt has an enable bit, a pending bit, an active bit, a handling-mode bit and a priority slot. Software-side logic updates this state through a single write port. Each write carries a bank select, a write kind, a slot-group index for priority writes, and 64 bits of data.

An interrupt competes only while it is enabled, pending and not active. Among the competitors, the one with the numerically smallest 5-bit priority wins, and the lowest interrupt number wins a tie. The winner is reported as a typed 32-bit identifier together with its priority. A priority of zero is the superpriority level and needs no separate flag.

The result comes from a registered comparison tree. After any write, a valid flag drops and stays low until the tree has settled on the new state.

Top module: `pirq_arbiter`

## Requirements
- R1: An interrupt is eligible only when its enable bit is 1, its pending bit is 1 and its active bit is 0; setting its active bit or clearing its enable bit removes it from the result.
- R2: Each priority slot is 8 bits wide, but only its low 5 bits are compared and reported; a smaller value is more urgent and the upper 3 bits have no effect.
- R3: With no eligible interrupt, best_prio is 8'hFF and best_id is 0.
- R4: A candidate displaces the current best only when its priority is strictly smaller, so the lowest interrupt number wins among equal priorities.
- R5: The interrupt number is bank × 64 + bit position in the bank, from 0 to 127; bit 63 of bank 1 is interrupt 127.
- R6: When an interrupt is eligible, best_id holds the interrupt number in bits 23:0, the private type code 3'b001 in bits 31:29 and zero in bits 28:24, and best_prio holds the 5-bit priority zero-extended to 8 bits.
- R7: A pending-set write (wr_kind 1) ORs the data into the pending bits, and a pending-clear write (wr_kind 2) clears the pending bits where the data is 1. In both, any data bit whose handling-mode bit is 1 is ignored.
- R8: Write kinds: 0 replaces the enable bits, 3 ORs the data into the active bits, 4 clears the active bits where the data is 1, and 5 replaces the handling-mode bits. Kind 6 replaces priority slots: byte k of wr_data (bits 8k+7:8k) goes to interrupt bank × 64 + wr_index × 8 + k. Kind 7 changes no state.
- R9: best_valid is 0 in the cycle after any accepted write, including kind 7. It returns to 1 exactly 7 clock edges after the last write, and from then on best_id and best_prio reflect every write made and stay stable until the next write.
- R10: After reset, all enable, pending, active and handling-mode bits are 0, every priority slot holds 8'hFF, best_valid is 1 and the output shows the idle result.
- R11: Priority 0 is superpriority: an eligible interrupt at priority 0 is reported with best_prio 8'h00 and beats every interrupt at a nonzero priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_bank | input | 1 | Bank selected by the write |
| wr_kind | input | 3 | Write kind (0 enable, 1 pending set, 2 pending clear, 3 active set, 4 active clear, 5 handling mode, 6 priority, 7 none) |
| wr_index | input | 3 | Group of eight priority slots written by kind 6 |
| wr_data | input | 64 | Write data |
| best_id | output | 32 | Typed identifier of the winning interrupt, 0 when idle |
| best_prio | output | 8 | Priority of the winner, 8'hFF when idle |
| best_valid | output | 1 | High when the result reflects all writes so far |

## Verification
A corrupted enable, pending, active or handling-mode bit, or a bad priority slot, shows up as a wrong best_id or best_prio at most seven edges after the write that exposes it. The bench therefore compares both outputs with a bench-side model at the moment best_valid returns. Write-port masking errors matter only when the masked interrupt would be the winner. For that reason every masking and tie scenario is arranged so that the interrupt under test would lead the result if it were wrongly admitted. A wrong settle count is seen directly on best_valid, one edge early or late.

// File: rtl/pirq_pkg.sv
// Package: shared encodings of the private interrupt priority arbiter.
// Assumes: write kinds fit in three bits; identifier type code is 3 bits.
package pirq_pkg;

    typedef enum logic [2:0] {
        KIND_ENABLE   = 3'd0,
        KIND_PEND_SET = 3'd1,
        KIND_PEND_CLR = 3'd2,
        KIND_ACT_SET  = 3'd3,
        KIND_ACT_CLR  = 3'd4,
        KIND_HMODE    = 3'd5,
        KIND_PRIO     = 3'd6,
        KIND_NONE     = 3'd7
    } wr_kind_e;

    localparam logic [2:0] PIRQ_TYPE_PRIVATE = 3'b001;
    localparam logic [7:0] PIRQ_PRIO_IDLE    = 8'hFF;

endpackage

// File: rtl/pirq_bank_regs.sv
// Module: per-interrupt state storage and eligibility.
// Holds enable, pending, active and handling-mode bits per bank, plus the
// compared low bits of each priority slot. Produces one eligibility bit and
// one compare priority per interrupt. Assumes one write per cycle and that
// BANK_W is a multiple of 8 slots per priority register.
module pirq_bank_regs #(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_W     = 64,
    parameter int SLOT_W     = 8,
    parameter int PRIO_W     = 5,
    parameter int BANK_SEL_W = 1,
    parameter int GRP_W      = 3,
    localparam int N           = NUM_BANKS * BANK_W,
    localparam int SLOTS_PER_W = BANK_W / SLOT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [BANK_SEL_W-1:0]   wr_bank,
    input  logic [2:0]              wr_kind,
    input  logic [GRP_W-1:0]        wr_index,
    input  logic [BANK_W-1:0]       wr_data,
    output logic [N-1:0]            elig,
    output logic [N*PRIO_W-1:0]     prio_flat
);
    import pirq_pkg::*;

    wr_kind_e kind;
    assign kind = wr_kind_e'(wr_kind);

    // One bank of bit-mask state per generate iteration.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] en_q, pe_q, ac_q, hm_q;
        logic [BANK_W-1:0] pend_data;
        logic              sel;

        assign sel       = wr_en && (wr_bank == BANK_SEL_W'(b));
        assign pend_data = wr_data & ~hm_q;

        // Purpose: apply set, clear and replace writes to this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= '0;
                pe_q <= '0;
                ac_q <= '0;
                hm_q <= '0;
            end else if (sel) begin
                case (kind)
                    KIND_ENABLE:   en_q <= wr_data;
                    KIND_PEND_SET: pe_q <= pe_q | pend_data;
                    KIND_PEND_CLR: pe_q <= pe_q & ~pend_data;
                    KIND_ACT_SET:  ac_q <= ac_q | wr_data;
                    KIND_ACT_CLR:  ac_q <= ac_q & ~wr_data;
                    KIND_HMODE:    hm_q <= wr_data;
                    default:       ;
                endcase
            end
        end

        assign elig[b*BANK_W +: BANK_W] = en_q & pe_q & ~ac_q;
    end

    // One priority slot per generate iteration; only compared bits are kept.
    for (genvar s = 0; s < N; s++) begin : g_slot
        localparam int SB = s / BANK_W;
        localparam int SG = (s % BANK_W) / SLOTS_PER_W;
        localparam int SK = s % SLOTS_PER_W;
        logic [PRIO_W-1:0] slot_q;
        logic              hit;

        assign hit = wr_en && (kind == KIND_PRIO) &&
                     (wr_bank == BANK_SEL_W'(SB)) && (wr_index == GRP_W'(SG));

        // Purpose: load this slot's byte from a priority write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '1;
            else if (hit)
                slot_q <= wr_data[SK*SLOT_W +: PRIO_W];
        end

        assign prio_flat[s*PRIO_W +: PRIO_W] = slot_q;
    end

endmodule

// File: rtl/pirq_tree.sv
// Module: registered priority comparison tree.
// Every internal node of a complete binary tree is a register holding
// {hit, priority, index}. The left child always covers lower interrupt
// numbers, so ties keep the left side. Assumes N is a power of two; the
// root settles LEVELS edges after its inputs change.
module pirq_tree #(
    parameter int N      = 128,
    parameter int PRIO_W = 5,
    localparam int IDX_W  = $clog2(N),
    localparam int NODE_W = 1 + PRIO_W + IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        elig,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output logic                root_hit,
    output logic [PRIO_W-1:0]   root_prio,
    output logic [IDX_W-1:0]    root_idx
);
    logic [NODE_W-1:0] leaf  [N];
    logic [NODE_W-1:0] inner [N-1];

    // Keep the left node unless the right one is strictly more urgent.
    function automatic logic [NODE_W-1:0] pick(input logic [NODE_W-1:0] a,
                                               input logic [NODE_W-1:0] b);
        logic              a_hit, b_hit;
        logic [PRIO_W-1:0] a_p, b_p;
        a_hit = a[NODE_W-1];
        b_hit = b[NODE_W-1];
        a_p   = a[NODE_W-2 -: PRIO_W];
        b_p   = b[NODE_W-2 -: PRIO_W];
        if (b_hit && (!a_hit || (b_p < a_p)))
            return b;
        return a;
    endfunction

    // Heap child lookup: indices at or above N-1 are leaves.
    function automatic logic [NODE_W-1:0] child(input int c,
                                                input logic [NODE_W-1:0] lv [N],
                                                input logic [NODE_W-1:0] iv [N-1]);
        if (c >= N - 1)
            return lv[c - (N - 1)];
        return iv[c];
    endfunction

    for (genvar j = 0; j < N; j++) begin : g_leaf
        assign leaf[j] = {elig[j], prio_flat[j*PRIO_W +: PRIO_W], IDX_W'(j)};
    end

    // Purpose: advance every tree level by one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N - 1; i++)
                inner[i] <= '0;
        end else begin
            for (int i = 0; i < N - 1; i++)
                inner[i] <= pick(child(2*i + 1, leaf, inner),
                                 child(2*i + 2, leaf, inner));
        end
    end

    assign root_hit  = inner[0][NODE_W-1];
    assign root_prio = inner[0][NODE_W-2 -: PRIO_W];
    assign root_idx  = inner[0][IDX_W-1:0];

endmodule

// File: rtl/pirq_settle.sv
// Module: settle tracker for the comparison tree.
// Counts edges since the last write and reports settled once LAT edges
// have passed. Assumes the tree latency is exactly LAT edges.
module pirq_settle #(
    parameter int LAT = 7,
    localparam int CNT_W = $clog2(LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic settled
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: restart on a write, otherwise count up to LAT and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_W'(LAT);
        else if (restart)
            cnt_q <= '0;
        else if (cnt_q != CNT_W'(LAT))
            cnt_q <= cnt_q + 1'b1;
    end

    assign settled = (cnt_q == CNT_W'(LAT));

endmodule

// File: rtl/pirq_arbiter.sv
// Module: private interrupt priority arbiter (top).
// Stores private interrupt state, selects the most urgent eligible
// interrupt through a registered tree, and packs it as a typed identifier.
// Assumes PRIO_W <= 8 and an interrupt number that fits the 24-bit field.
module pirq_arbiter #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 64,
    parameter int SLOT_W    = 8,
    parameter int PRIO_W    = 5,
    localparam int N          = NUM_BANKS * BANK_W,
    localparam int IDX_W      = $clog2(N),
    localparam int LAT        = IDX_W,
    localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int GRP_W      = $clog2(SLOT_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [BANK_SEL_W-1:0] wr_bank,
    input  logic [2:0]            wr_kind,
    input  logic [GRP_W-1:0]      wr_index,
    input  logic [BANK_W-1:0]     wr_data,
    output logic [31:0]           best_id,
    output logic [7:0]            best_prio,
    output logic                  best_valid
);
    import pirq_pkg::*;

    logic [N-1:0]        elig;
    logic [N*PRIO_W-1:0] prio_flat;
    logic                root_hit;
    logic [PRIO_W-1:0]   root_prio;
    logic [IDX_W-1:0]    root_idx;

    pirq_bank_regs #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .SLOT_W    (SLOT_W),
        .PRIO_W    (PRIO_W),
        .BANK_SEL_W(BANK_SEL_W),
        .GRP_W     (GRP_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_kind  (wr_kind),
        .wr_index (wr_index),
        .wr_data  (wr_data),
        .elig     (elig),
        .prio_flat(prio_flat)
    );

    pirq_tree #(
        .N     (N),
        .PRIO_W(PRIO_W)
    ) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (elig),
        .prio_flat(prio_flat),
        .root_hit (root_hit),
        .root_prio(root_prio),
        .root_idx (root_idx)
    );

    pirq_settle #(
        .LAT(LAT)
    ) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(wr_en),
        .settled(best_valid)
    );

    // Purpose: pack the root node into the typed identifier and priority.
    always_comb begin
        if (root_hit) begin
            best_id   = {PIRQ_TYPE_PRIVATE, {(29 - IDX_W){1'b0}}, root_idx};
            best_prio = {{(8 - PRIO_W){1'b0}}, root_prio};
        end else begin
            best_id   = '0;
            best_prio = PIRQ_PRIO_IDLE;
        end
    end

endmodule

// File: rtl/pirq_arbiter_chk.sv
// Module: assertion checker for pirq_arbiter, attached with bind.
// Keeps its own count of edges since the last write.
module pirq_arbiter_chk #(
    parameter int LAT    = 7,
    parameter int IDX_W  = 7,
    parameter int PRIO_W = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] best_id,
    input logic [7:0]  best_prio,
    input logic        best_valid
);
    logic [7:0] since_wr;

    // Purpose: independent edge count since the most recent write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_wr <= 8'(LAT);
        else if (wr_en)
            since_wr <= '0;
        else if (since_wr != 8'(LAT))
            since_wr <= since_wr + 8'd1;
    end

    assert_idle_id_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (best_prio == 8'hFF) |-> (best_id == 32'd0));

    assert_id_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (best_prio != 8'hFF) |-> ((best_id[31:29] == 3'b001) &&
                                  (best_id[28:IDX_W] == '0) &&
                                  (best_prio[7:PRIO_W] == '0)));

    assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !best_valid);

    assert_valid_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_wr == 8'(LAT - 1)) && !wr_en) |=> best_valid);

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (best_valid && !wr_en) |=> (best_valid && $stable(best_id) && $stable(best_prio)));

endmodule

bind pirq_arbiter pirq_arbiter_chk #(
    .LAT   (LAT),
    .IDX_W (IDX_W),
    .PRIO_W(PRIO_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .best_id   (best_id),
    .best_prio (best_prio),
    .best_valid(best_valid)
);

// File: tb/sim_pirq_arbiter.sv
// Bench: directed scenarios for pirq_arbiter against a bench-side model.
module sim_pirq_arbiter;
    localparam int LAT = 7;
    localparam logic [2:0] K_EN = 3'd0, K_PSET = 3'd1, K_PCLR = 3'd2, K_ASET = 3'd3,
                           K_ACLR = 3'd4, K_HM = 3'd5, K_PRIO = 3'd6, K_NOP = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_bank = '0;
    logic [2:0]  wr_kind = '0;
    logic [2:0]  wr_index = '0;
    logic [63:0] wr_data = '0;
    logic [31:0] best_id;
    logic [7:0]  best_prio;
    logic        best_valid;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] m_en [2];
    logic [63:0] m_pe [2];
    logic [63:0] m_ac [2];
    logic [63:0] m_hm [2];
    logic [4:0]  m_pr [128];

    always #5 clk = ~clk;

    pirq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_kind(wr_kind), .wr_index(wr_index), .wr_data(wr_data),
        .best_id(best_id), .best_prio(best_prio), .best_valid(best_valid)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write one register and mirror it in the model; returns after the edge.
    task automatic do_write(input int bank, input logic [2:0] kind,
                            input int idx, input logic [63:0] data);
        logic [63:0] pd;
        pd = data & ~m_hm[bank];
        case (kind)
            K_EN:   m_en[bank] = data;
            K_PSET: m_pe[bank] = m_pe[bank] | pd;
            K_PCLR: m_pe[bank] = m_pe[bank] & ~pd;
            K_ASET: m_ac[bank] = m_ac[bank] | data;
            K_ACLR: m_ac[bank] = m_ac[bank] & ~data;
            K_HM:   m_hm[bank] = data;
            K_PRIO: for (int k = 0; k < 8; k++) m_pr[bank*64 + idx*8 + k] = data[k*8 +: 5];
            default: ;
        endcase
        wr_en = 1'b1; wr_bank = 1'(bank); wr_kind = kind; wr_index = 3'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Replace one priority slot, keeping its neighbours at their model values.
    task automatic set_prio(input int n, input logic [7:0] val);
        logic [63:0] d;
        int base;
        base = (n / 8) * 8;
        for (int k = 0; k < 8; k++) d[k*8 +: 8] = {3'b000, m_pr[base + k]};
        d[(n % 8)*8 +: 8] = val;
        do_write(n / 64, K_PRIO, (n % 64) / 8, d);
    endtask

    task automatic model_best(output logic [31:0] eid, output logic [7:0] ep);
        logic found;
        logic [4:0] bp;
        found = 1'b0; bp = '1; eid = '0; ep = 8'hFF;
        for (int n = 0; n < 128; n++) begin
            if (m_en[n/64][n%64] && m_pe[n/64][n%64] && !m_ac[n/64][n%64]) begin
                if (!found || m_pr[n] < bp) begin
                    found = 1'b1; bp = m_pr[n];
                    eid = {3'b001, 22'd0, 7'(n)};
                    ep = {3'b000, m_pr[n]};
                end
            end
        end
    endtask

    // Wait out the tree latency and compare the outputs with the model.
    task automatic settle_cmp(input string req);
        logic [31:0] eid;
        logic [7:0] ep;
        repeat (LAT) @(negedge clk);
        model_best(eid, ep);
        chk({req, " valid"}, 64'(best_valid), 64'd1);
        chk({req, " id"}, 64'(best_id), 64'(eid));
        chk({req, " prio"}, 64'(best_prio), 64'(ep));
    endtask

    task automatic t_reset;
        chk("R10 valid after reset", 64'(best_valid), 64'd1);
        chk("R10 R3 idle prio", 64'(best_prio), 64'hFF);
        chk("R10 R3 idle id", 64'(best_id), 64'd0);
        do_write(0, K_EN, 0, 64'h1);
        do_write(0, K_PSET, 0, 64'h1);
        settle_cmp("R10 reset slot 0xFF compares as 31");
        chk("R10 slot reset prio", 64'(best_prio), 64'h1F);
        do_write(0, K_EN, 0, 64'h0);
        settle_cmp("R3 idle again");
    endtask

    task automatic t_single;
        set_prio(5, 8'h10);
        do_write(0, K_EN, 0, 64'h20);
        do_write(0, K_PSET, 0, 64'h20);
        settle_cmp("R1 R6 single");
        chk("R6 id of interrupt 5", 64'(best_id), 64'h2000_0005);
        chk("R8 byte 5 to slot 5", 64'(best_prio), 64'h10);
    endtask

    task automatic t_low5;
        set_prio(70, 8'hE3);
        do_write(1, K_EN, 0, 64'h40);
        do_write(1, K_PSET, 0, 64'h40);
        settle_cmp("R2 R5 upper bits ignored");
        chk("R5 id 70", 64'(best_id), 64'h2000_0046);
        chk("R2 prio low5", 64'(best_prio), 64'h03);
    endtask

    task automatic t_tie;
        set_prio(20, 8'h03);
        do_write(0, K_EN, 0, 64'h0010_0020);
        do_write(0, K_PSET, 0, 64'h0010_0000);
        settle_cmp("R4 tie lowest number");
        chk("R4 20 beats 70", 64'(best_id), 64'h2000_0014);
    endtask

    task automatic t_active;
        do_write(0, K_ASET, 0, 64'h0010_0000);
        settle_cmp("R1 active excluded");
        chk("R1 70 after active", 64'(best_id), 64'h2000_0046);
        do_write(0, K_ACLR, 0, 64'h0010_0000);
        settle_cmp("R8 active clear");
        chk("R8 20 back", 64'(best_id), 64'h2000_0014);
        do_write(0, K_EN, 0, 64'h20);
        settle_cmp("R1 enable cleared");
        chk("R1 70 after disable", 64'(best_id), 64'h2000_0046);
    endtask

    task automatic t_hmode;
        do_write(1, K_HM, 0, 64'h40);
        do_write(1, K_PCLR, 0, 64'h40);
        settle_cmp("R7 masked clear");
        chk("R7 70 stays pending", 64'(best_id), 64'h2000_0046);
        set_prio(9, 8'h00);
        do_write(0, K_HM, 0, 64'h200);
        do_write(0, K_EN, 0, 64'h220);
        do_write(0, K_PSET, 0, 64'h200);
        settle_cmp("R7 masked set");
        chk("R7 9 not pending", 64'(best_id), 64'h2000_0046);
        do_write(0, K_HM, 0, 64'h0);
        do_write(0, K_PSET, 0, 64'h200);
        settle_cmp("R11 superpriority");
        chk("R11 id 9", 64'(best_id), 64'h2000_0009);
        chk("R11 prio zero", 64'(best_prio), 64'h00);
    endtask

    task automatic t_top_index;
        set_prio(127, 8'h00);
        do_write(1, K_EN, 0, 64'h8000_0000_0000_0040);
        do_write(1, K_PSET, 0, 64'h8000_0000_0000_0000);
        settle_cmp("R4 equal zero prio");
        chk("R4 9 beats 127", 64'(best_id), 64'h2000_0009);
        do_write(0, K_PCLR, 0, 64'h200);
        settle_cmp("R5 top index");
        chk("R5 id 127", 64'(best_id), 64'h2000_007F);
    endtask

    task automatic t_noop;
        do_write(0, K_NOP, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R9 valid low after no-op", 64'(best_valid), 64'd0);
        settle_cmp("R8 no-op keeps state");
        chk("R8 id after no-op", 64'(best_id), 64'h2000_007F);
    endtask

    task automatic t_timing;
        do_write(1, K_ACLR, 0, 64'h0);
        do_write(1, K_ASET, 0, 64'h8000_0000_0000_0000);
        chk("R9 valid low after burst", 64'(best_valid), 64'd0);
        repeat (LAT - 1) @(negedge clk);
        chk("R9 valid low one edge early", 64'(best_valid), 64'd0);
        @(negedge clk);
        chk("R9 valid high at latency", 64'(best_valid), 64'd1);
        chk("R9 burst result", 64'(best_id), 64'h2000_0046);
    endtask

    task automatic t_idle;
        do_write(0, K_EN, 0, 64'h0);
        do_write(1, K_EN, 0, 64'h0);
        settle_cmp("R3 all disabled");
        chk("R3 idle id", 64'(best_id), 64'd0);
        chk("R3 idle prio", 64'(best_prio), 64'hFF);
    endtask

    initial begin
        for (int b = 0; b < 2; b++) begin
            m_en[b] = '0; m_pe[b] = '0; m_ac[b] = '0; m_hm[b] = '0;
        end
        for (int n = 0; n < 128; n++) m_pr[n] = 5'h1F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_single;
        t_low5;
        t_tie;
        t_active;
        t_hmode;
        t_top_index;
        t_noop;
        t_timing;
        t_idle;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule